// File: doc/BRIEF.md
# Single-Outstanding AXI4 Load-Store Port

This block sits between a processor pipeline and a 32-bit AXI4 data bus. The core pulses a start request that carries an address, an access width, a sign flag for loads, a direction and the store data. The port turns that request into one single-beat AXI4 transaction: a read on AR/R, or a write on AW/W/B. It then reports completion with a one-cycle done pulse. Load data comes back already shifted down to bit 0 and extended to the full width.

Only one transaction is in flight at a time. While a transaction is pending the port is busy and ignores further requests. A request whose address does not fit its access width never reaches the bus and ends at once with a misaligned fault. A non-zero bus response code ends the transaction with an access fault. Memory is little-endian, so byte lane n carries the byte at address offset n.

Top module: `axi_ldst_port`

## Requirements
- R1: The port accepts a request only while `idle_o` is high. A request that arrives while a transaction is pending is ignored: it starts no bus activity of either direction, and the pending transaction is not disturbed.
- R2: Size encoding on `req_size_i` is 0 byte, 1 halfword, 2 word. The AR or AW size output carries the same value, zero-extended to 3 bits.
- R3: An access is misaligned when the address low bits are not a multiple of the access width, or when the size code is the reserved value 3. Such an access raises no valid on any channel. It gives `done_o` together with `fault_misalign_o` in the cycle right after the request edge. An aligned access drives the request address unchanged on AR or AW.
- R4: For a store, write strobe bit n is high exactly for the byte lanes being written. A byte sets only the lane equal to address bits [1:0]. A halfword sets lanes 1:0 or 3:2, chosen by address bit 1. A word sets all four lanes.
- R5: Store data is replicated so that it lines up with the strobe. The low byte is copied to every lane for a byte store, the low halfword to both halves for a halfword store, and the word is passed unchanged.
- R6: The write-last output and both response-ready outputs are always 1. Both protection outputs are always 0.
- R7: A non-zero B or R response code gives `fault_access_o` high together with `done_o`. A zero code gives it low.
- R8: Load data is taken from the bus word starting at byte lane address[1:0] (little-endian). It is sign-extended when `req_signed_i` is 1 and zero-extended otherwise, and it is held on `rdata_o` after the done pulse.
- R9: For an aligned store, AW valid and W valid rise together in the cycle after the request edge. Each stays high until its own handshake and drops in the next cycle, independently of the other. For an aligned load, AR valid behaves the same way.
- R10: `done_o` is a one-cycle pulse in the cycle after the edge at which the R or B response handshake occurs. It is high only while the port is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start pulse for a request |
| req_write_i | input | 1 | 1 store, 0 load |
| req_addr_i | input | 32 | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed_i | input | 1 | Sign-extend load data |
| req_wdata_i | input | 32 | Store data, right-aligned |
| idle_o | output | 1 | No transaction pending; a request is accepted |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | 32 | Aligned, extended load data |
| fault_misalign_o | output | 1 | Misaligned fault, valid with done_o |
| fault_access_o | output | 1 | Bus error fault, valid with done_o |
| m_awaddr_o | output | 32 | Write address |
| m_awprot_o | output | 3 | Write protection, constant |
| m_awsize_o | output | 3 | Write size |
| m_awvalid_o | output | 1 | Write address valid |
| m_awready_i | input | 1 | Write address ready |
| m_wdata_o | output | 32 | Write data |
| m_wstrb_o | output | 4 | Write strobes |
| m_wlast_o | output | 1 | Last beat, constant 1 |
| m_wvalid_o | output | 1 | Write data valid |
| m_wready_i | input | 1 | Write data ready |
| m_bvalid_i | input | 1 | Write response valid |
| m_bresp_i | input | 2 | Write response code |
| m_bready_o | output | 1 | Write response ready, constant 1 |
| m_araddr_o | output | 32 | Read address |
| m_arprot_o | output | 3 | Read protection, constant |
| m_arsize_o | output | 3 | Read size |
| m_arvalid_o | output | 1 | Read address valid |
| m_arready_i | input | 1 | Read address ready |
| m_rdata_i | input | 32 | Read data |
| m_rvalid_i | input | 1 | Read data valid |
| m_rresp_i | input | 2 | Read response code |
| m_rready_o | output | 1 | Read data ready, constant 1 |

## Verification
A misaligned fault is due one cycle after the request edge, and the address valids are due at that same point for aligned requests. `done_o`, its fault flags and new `rdata_o` are due exactly one cycle after the response handshake edge. The bench plays the bus subordinate cycle by cycle on falling edges. It records the falling edge on which it raised R or B valid and requires the done pulse on the very next falling edge, not merely at some later point. Address valids are checked on the first falling edge after the request. Each valid must be gone on the falling edge that follows its handshake.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } port_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/ldst_lane_map.sv
// Request-side lane logic: alignment check, strobes, store data replication.
module ldst_lane_map #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / ldst_pkg::BYTE_W,
  localparam int unsigned OFF_W  = $clog2(STRB_W)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              misaligned_o,
  output logic [STRB_W-1:0] strb_o,
  output logic [DATA_W-1:0] lanes_o
);
  logic [OFF_W-1:0] sz_mask;
  logic             sz_ok;

  always_comb begin
    sz_mask      = OFF_W'((32'd1 << size_i) - 32'd1);
    sz_ok        = (int'(size_i) <= int'(OFF_W)) && (size_i != 2'd3);
    misaligned_o = !sz_ok || (|(off_i & sz_mask));
  end

  for (genvar i = 0; i < STRB_W; i++) begin : lane_g
    logic [OFF_W-1:0] src;
    assign src       = OFF_W'(i) & sz_mask;
    assign strb_o[i] = ((OFF_W'(i) & ~sz_mask) == (off_i & ~sz_mask));
    assign lanes_o[ldst_pkg::BYTE_W*i +: ldst_pkg::BYTE_W] = data_i[{src, 3'b000} +: ldst_pkg::BYTE_W];
  end
endmodule

// File: rtl/ldst_load_fmt.sv
// Shifts the addressed bytes down to bit 0 and extends to full width.
module ldst_load_fmt #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / ldst_pkg::BYTE_W,
  localparam int unsigned OFF_W  = $clog2(STRB_W)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shifted;
  logic              fill;
  int                top;

  always_comb begin
    shifted = data_i >> {off_i, 3'b000};
    top     = (ldst_pkg::BYTE_W << size_i) - 1;
    if (top > int'(DATA_W) - 1) top = int'(DATA_W) - 1;
    fill    = signed_i & shifted[top];
    for (int j = 0; j < int'(DATA_W); j++) begin
      data_o[j] = (j <= top) ? shifted[j] : fill;
    end
  end
endmodule

// File: rtl/ldst_ctrl.sv
// Transaction sequencer: one outstanding access, independent AW/W drop.
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic write_i,
  input  logic misaligned_i,
  input  logic aw_ready_i,
  input  logic w_ready_i,
  input  logic b_valid_i,
  input  logic b_err_i,
  input  logic ar_ready_i,
  input  logic r_valid_i,
  input  logic r_err_i,
  output logic idle_o,
  output logic accept_o,
  output logic aw_valid_o,
  output logic w_valid_o,
  output logic ar_valid_o,
  output logic rd_capture_o,
  output logic done_o,
  output logic fault_mis_o,
  output logic fault_acc_o
);
  port_state_e state_q;
  logic aw_pend_q, w_pend_q, ar_pend_q;
  logic done_q, mis_q, acc_q;

  assign idle_o       = (state_q == ST_IDLE);
  assign accept_o     = idle_o && start_i && !misaligned_i;
  assign rd_capture_o = (state_q == ST_LOAD) && r_valid_i;
  assign aw_valid_o   = aw_pend_q;
  assign w_valid_o    = w_pend_q;
  assign ar_valid_o   = ar_pend_q;
  assign done_o       = done_q;
  assign fault_mis_o  = mis_q;
  assign fault_acc_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      ar_pend_q <= 1'b0;
      done_q    <= 1'b0;
      mis_q     <= 1'b0;
      acc_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      mis_q  <= 1'b0;
      acc_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (misaligned_i) begin
              done_q <= 1'b1;
              mis_q  <= 1'b1;
            end else if (write_i) begin
              state_q   <= ST_STORE;
              aw_pend_q <= 1'b1;
              w_pend_q  <= 1'b1;
            end else begin
              state_q   <= ST_LOAD;
              ar_pend_q <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (ar_pend_q && ar_ready_i) ar_pend_q <= 1'b0;
          if (r_valid_i) begin
            done_q  <= 1'b1;
            acc_q   <= r_err_i;
            state_q <= ST_IDLE;
          end
        end
        ST_STORE: begin
          if (aw_pend_q && aw_ready_i) aw_pend_q <= 1'b0;
          if (w_pend_q && w_ready_i)   w_pend_q  <= 1'b0;
          if (b_valid_i) begin
            done_q  <= 1'b1;
            acc_q   <= b_err_i;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_ldst_port.sv
module axi_ldst_port #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [2:0]  PROT   = 3'b000,
  localparam int unsigned STRB_W = DATA_W / ldst_pkg::BYTE_W,
  localparam int unsigned OFF_W  = $clog2(STRB_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fault_misalign_o,
  output logic              fault_access_o,
  output logic [ADDR_W-1:0] m_awaddr_o,
  output logic [2:0]        m_awprot_o,
  output logic [2:0]        m_awsize_o,
  output logic              m_awvalid_o,
  input  logic              m_awready_i,
  output logic [DATA_W-1:0] m_wdata_o,
  output logic [STRB_W-1:0] m_wstrb_o,
  output logic              m_wlast_o,
  output logic              m_wvalid_o,
  input  logic              m_wready_i,
  input  logic              m_bvalid_i,
  input  logic [1:0]        m_bresp_i,
  output logic              m_bready_o,
  output logic [ADDR_W-1:0] m_araddr_o,
  output logic [2:0]        m_arprot_o,
  output logic [2:0]        m_arsize_o,
  output logic              m_arvalid_o,
  input  logic              m_arready_i,
  input  logic [DATA_W-1:0] m_rdata_i,
  input  logic              m_rvalid_i,
  input  logic [1:0]        m_rresp_i,
  output logic              m_rready_o
);
  logic              misaligned, accept, rd_capture;
  logic [STRB_W-1:0] strb_d;
  logic [DATA_W-1:0] lanes_d, load_fmt;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              sign_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [STRB_W-1:0] strb_q;

  ldst_lane_map #(.DATA_W(DATA_W)) u_lane (
    .off_i        (req_addr_i[OFF_W-1:0]),
    .size_i       (req_size_i),
    .data_i       (req_wdata_i),
    .misaligned_o (misaligned),
    .strb_o       (strb_d),
    .lanes_o      (lanes_d)
  );

  ldst_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (req_valid_i),
    .write_i      (req_write_i),
    .misaligned_i (misaligned),
    .aw_ready_i   (m_awready_i),
    .w_ready_i    (m_wready_i),
    .b_valid_i    (m_bvalid_i),
    .b_err_i      (|m_bresp_i),
    .ar_ready_i   (m_arready_i),
    .r_valid_i    (m_rvalid_i),
    .r_err_i      (|m_rresp_i),
    .idle_o       (idle_o),
    .accept_o     (accept),
    .aw_valid_o   (m_awvalid_o),
    .w_valid_o    (m_wvalid_o),
    .ar_valid_o   (m_arvalid_o),
    .rd_capture_o (rd_capture),
    .done_o       (done_o),
    .fault_mis_o  (fault_misalign_o),
    .fault_acc_o  (fault_access_o)
  );

  ldst_load_fmt #(.DATA_W(DATA_W)) u_fmt (
    .off_i    (addr_q[OFF_W-1:0]),
    .size_i   (size_q),
    .signed_i (sign_q),
    .data_i   (m_rdata_i),
    .data_o   (load_fmt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= 2'd0;
      sign_q  <= 1'b0;
      wdata_q <= '0;
      strb_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      size_q  <= req_size_i;
      sign_q  <= req_signed_i;
      wdata_q <= lanes_d;
      strb_q  <= strb_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_q <= '0;
    else if (rd_capture) rdata_q <= load_fmt;
  end

  assign rdata_o    = rdata_q;
  assign m_awaddr_o = addr_q;
  assign m_araddr_o = addr_q;
  assign m_awsize_o = {1'b0, size_q};
  assign m_arsize_o = {1'b0, size_q};
  assign m_awprot_o = PROT;
  assign m_arprot_o = PROT;
  assign m_wdata_o  = wdata_q;
  assign m_wstrb_o  = strb_q;
  assign m_wlast_o  = 1'b1;
  assign m_bready_o = 1'b1;
  assign m_rready_o = 1'b1;
endmodule

// File: rtl/axi_ldst_port_chk.sv
module axi_ldst_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        idle_o,
  input logic        done_o,
  input logic        fault_misalign_o,
  input logic        fault_access_o,
  input logic        m_awvalid_o,
  input logic        m_awready_i,
  input logic        m_wvalid_o,
  input logic [3:0]  m_wstrb_o,
  input logic        m_wlast_o,
  input logic        m_bvalid_i,
  input logic [1:0]  m_bresp_i,
  input logic        m_bready_o,
  input logic [31:0] m_araddr_o,
  input logic [2:0]  m_arprot_o,
  input logic [2:0]  m_awprot_o,
  input logic [2:0]  m_arsize_o,
  input logic        m_arvalid_o,
  input logic        m_arready_i,
  input logic        m_rready_o
);
  // R1
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_arvalid_o && (m_awvalid_o || m_wvalid_o)));

  // R1
  ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_arvalid_o && !m_arready_i) |=> (m_arvalid_o && $stable(m_araddr_o)));

  // R3
  ar_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o |-> (({1'b0, m_araddr_o[1:0]} & ((3'd1 << m_arsize_o) - 3'd1)) == 3'd0));

  // R3
  mis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_misalign_o |-> (!m_arvalid_o && !m_awvalid_o && !m_wvalid_o && done_o));

  // R4
  strb_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_wvalid_o |-> (m_wstrb_o != 4'd0));

  // R6
  tie_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_wlast_o && m_bready_o && m_rready_o && (m_arprot_o == 3'd0) && (m_awprot_o == 3'd0));

  // R7
  berr_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && m_bvalid_i && (m_bresp_i != 2'd0)) |=> (done_o && fault_access_o));

  // R9
  aw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_o && !m_awready_i) |=> m_awvalid_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> idle_o);
endmodule

bind axi_ldst_port axi_ldst_port_chk chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .idle_o           (idle_o),
  .done_o           (done_o),
  .fault_misalign_o (fault_misalign_o),
  .fault_access_o   (fault_access_o),
  .m_awvalid_o      (m_awvalid_o),
  .m_awready_i      (m_awready_i),
  .m_wvalid_o       (m_wvalid_o),
  .m_wstrb_o        (m_wstrb_o),
  .m_wlast_o        (m_wlast_o),
  .m_bvalid_i       (m_bvalid_i),
  .m_bresp_i        (m_bresp_i),
  .m_bready_o       (m_bready_o),
  .m_araddr_o       (m_araddr_o),
  .m_arprot_o       (m_arprot_o),
  .m_awprot_o       (m_awprot_o),
  .m_arsize_o       (m_arsize_o),
  .m_arvalid_o      (m_arvalid_o),
  .m_arready_i      (m_arready_i),
  .m_rready_o       (m_rready_o)
);

// File: tb/axi_ldst_port_tb_top.sv
`timescale 1ns/1ps
module axi_ldst_port_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        req_valid_i = 0, req_write_i = 0, req_signed_i = 0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        idle_o, done_o, fault_misalign_o, fault_access_o;
  logic [31:0] rdata_o, m_awaddr_o, m_wdata_o, m_araddr_o;
  logic [2:0]  m_awprot_o, m_awsize_o, m_arprot_o, m_arsize_o;
  logic [3:0]  m_wstrb_o;
  logic        m_awvalid_o, m_wvalid_o, m_wlast_o, m_bready_o, m_arvalid_o, m_rready_o;
  logic        m_awready_i = 0, m_wready_i = 0, m_bvalid_i = 0, m_arready_i = 0, m_rvalid_i = 0;
  logic [1:0]  m_bresp_i = '0, m_rresp_i = '0;
  logic [31:0] m_rdata_i = '0;

  axi_ldst_port dut_i (.*);

  int n_chk = 0, n_fail = 0;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        sgn;
    logic [31:0] wd;
    logic [31:0] bus;
    logic [1:0]  resp;
    logic [1:0]  d0;
    logic [1:0]  d1;
    logic [31:0] exp;
    logic [3:0]  strb;
    logic        mis;
    logic        acc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h100, 2'd0, 1'b1, 32'h0, 32'h8899AABB, 2'd0, 2'd0, 2'd0, 32'hFFFFFFBB, 4'h0, 1'b0, 1'b0},
    '{1'b0, 32'h103, 2'd0, 1'b0, 32'h0, 32'h8899AABB, 2'd0, 2'd1, 2'd0, 32'h00000088, 4'h0, 1'b0, 1'b0},
    '{1'b0, 32'h102, 2'd0, 1'b1, 32'h0, 32'h8899AABB, 2'd0, 2'd2, 2'd0, 32'hFFFFFF99, 4'h0, 1'b0, 1'b0},
    '{1'b0, 32'h102, 2'd1, 1'b1, 32'h0, 32'h8899AABB, 2'd0, 2'd0, 2'd0, 32'hFFFF8899, 4'h0, 1'b0, 1'b0},
    '{1'b0, 32'h100, 2'd1, 1'b0, 32'h0, 32'h8899AABB, 2'd0, 2'd0, 2'd0, 32'h0000AABB, 4'h0, 1'b0, 1'b0},
    '{1'b0, 32'h104, 2'd2, 1'b1, 32'h0, 32'h8899AABB, 2'd0, 2'd3, 2'd0, 32'h8899AABB, 4'h0, 1'b0, 1'b0},
    '{1'b0, 32'h101, 2'd0, 1'b1, 32'h0, 32'h12345678, 2'd0, 2'd0, 2'd0, 32'h00000056, 4'h0, 1'b0, 1'b0},
    '{1'b1, 32'h101, 2'd0, 1'b0, 32'h000000A5, 32'h0, 2'd0, 2'd0, 2'd2, 32'hA5A5A5A5, 4'b0010, 1'b0, 1'b0},
    '{1'b1, 32'h102, 2'd1, 1'b0, 32'h0000BEEF, 32'h0, 2'd0, 2'd3, 2'd0, 32'hBEEFBEEF, 4'b1100, 1'b0, 1'b0},
    '{1'b1, 32'h108, 2'd2, 1'b0, 32'hDEADBEEF, 32'h0, 2'd0, 2'd1, 2'd1, 32'hDEADBEEF, 4'b1111, 1'b0, 1'b0},
    '{1'b0, 32'h10C, 2'd2, 1'b0, 32'h0, 32'h8899AABB, 2'd2, 2'd0, 2'd0, 32'h8899AABB, 4'h0, 1'b0, 1'b1},
    '{1'b1, 32'h103, 2'd0, 1'b0, 32'h11223344, 32'h0, 2'd3, 2'd0, 2'd0, 32'h44444444, 4'b1000, 1'b0, 1'b1},
    '{1'b0, 32'h101, 2'd1, 1'b0, 32'h0, 32'h0, 2'd0, 2'd0, 2'd0, 32'h0, 4'h0, 1'b1, 1'b0},
    '{1'b1, 32'h10A, 2'd2, 1'b0, 32'h55, 32'h0, 2'd0, 2'd0, 2'd0, 32'h0, 4'h0, 1'b1, 1'b0},
    '{1'b0, 32'h106, 2'd2, 1'b0, 32'h0, 32'h0, 2'd0, 2'd0, 2'd0, 32'h0, 4'h0, 1'b1, 1'b0},
    '{1'b0, 32'h100, 2'd3, 1'b0, 32'h0, 32'h0, 2'd0, 2'd0, 2'd0, 32'h0, 4'h0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v, input bit intrude);
    bit ar_hs = 0, aw_hs = 0, w_hs = 0, resp_sent = 0, got_done = 0, hs_err = 0, stray = 0;
    int resp_k = -10, done_k = -1;
    logic [31:0] s_addr = '0, s_wdata = '0, s_rdata = '0;
    logic [2:0]  s_size = '0;
    logic [3:0]  s_strb = '0;
    logic        s_mis = 0, s_acc = 0;
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = v.wr; req_addr_i = v.addr;
    req_size_i = v.size; req_signed_i = v.sgn; req_wdata_i = v.wd;
    @(negedge clk_i);
    req_valid_i = intrude;
    if (intrude) begin
      req_write_i = 1; req_addr_i = 32'h200; req_size_i = 2'd2; req_wdata_i = 32'hFFFFFFFF;
    end
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk_i);
      if (k == 1) req_valid_i = 0;
      if (done_o) begin
        got_done = 1; done_k = k;
        s_rdata = rdata_o; s_mis = fault_misalign_o; s_acc = fault_access_o;
        m_rvalid_i = 0; m_bvalid_i = 0;
        m_arready_i = 0; m_awready_i = 0; m_wready_i = 0;
        break;
      end
      m_rvalid_i = 0; m_bvalid_i = 0;
      if (v.mis && (m_arvalid_o || m_awvalid_o || m_wvalid_o)) stray = 1;
      if (!v.wr && (m_awvalid_o || m_wvalid_o)) stray = 1;
      if (v.wr && m_arvalid_o) stray = 1;
      if (!v.mis && k == 0) begin
        if (v.wr && !(m_awvalid_o && m_wvalid_o)) hs_err = 1;
        if (!v.wr && !m_arvalid_o) hs_err = 1;
      end
      if (ar_hs && m_arvalid_o) hs_err = 1;
      if (aw_hs && m_awvalid_o) hs_err = 1;
      if (w_hs && m_wvalid_o) hs_err = 1;
      if (!v.mis && v.wr && !aw_hs && !m_awvalid_o) hs_err = 1;
      if (!v.mis && v.wr && !w_hs && !m_wvalid_o) hs_err = 1;
      if (!resp_sent && ((!v.wr && ar_hs) || (v.wr && aw_hs && w_hs))) begin
        resp_sent = 1; resp_k = k;
        if (v.wr) begin m_bvalid_i = 1; m_bresp_i = v.resp; end
        else begin m_rvalid_i = 1; m_rresp_i = v.resp; m_rdata_i = v.bus; end
      end
      m_arready_i = m_arvalid_o && (k >= int'(v.d0));
      m_awready_i = m_awvalid_o && (k >= int'(v.d0));
      m_wready_i  = m_wvalid_o && (k >= int'(v.d1));
      if (m_arvalid_o && m_arready_i) begin ar_hs = 1; s_addr = m_araddr_o; s_size = m_arsize_o; end
      if (m_awvalid_o && m_awready_i) begin aw_hs = 1; s_addr = m_awaddr_o; s_size = m_awsize_o; end
      if (m_wvalid_o && m_wready_i) begin w_hs = 1; s_wdata = m_wdata_o; s_strb = m_wstrb_o; end
    end
    req_valid_i = 0;
    chk("R10 done pulse seen", 32'(got_done), 32'd1);
    chk("R3 misaligned flag", 32'(s_mis), 32'(v.mis));
    chk("R1 no stray channel activity", 32'(stray), 32'd0);
    if (v.mis) begin
      chk("R3 misaligned done latency", 32'(done_k), 32'd0);
    end else begin
      chk("R10 done one cycle after response", 32'(done_k), 32'(resp_k + 1));
      chk("R9 valid rise/drop", 32'(hs_err), 32'd0);
      chk("R7 access fault", 32'(s_acc), 32'(v.acc));
      chk("R2 bus size", 32'(s_size), {29'd0, 1'b0, v.size});
      chk("R3 bus address", s_addr, v.addr);
      if (v.wr) begin
        chk("R5 store lanes", s_wdata, v.exp);
        chk("R4 strobes", 32'(s_strb), 32'(v.strb));
      end else if (!v.acc) begin
        chk("R8 load data", s_rdata, v.exp);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    chk("R1 idle after reset", 32'(idle_o), 32'd1);
    chk("R10 no done after reset", 32'(done_o), 32'd0);
    chk("R9 no valids after reset", {29'd0, m_arvalid_o, m_awvalid_o, m_wvalid_o}, 32'd0);
    chk("R6 ties high", {29'd0, m_wlast_o, m_bready_o, m_rready_o}, 32'd7);
    chk("R6 prot zero", {26'd0, m_arprot_o, m_awprot_o}, 32'd0);

    for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0);

    // R1: store request during a pending load with delayed AR ready is ignored
    run_txn('{1'b0, 32'h110, 2'd2, 1'b0, 32'h0, 32'hCAFEF00D, 2'd0, 2'd3, 2'd0,
              32'hCAFEF00D, 4'h0, 1'b0, 1'b0}, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R1 intruding store never issued", {30'd0, m_awvalid_o, m_wvalid_o}, 32'd0);
    chk("R1 idle after ignored request", 32'(idle_o), 32'd1);
    // R8: rdata held after a following store
    chk("R8 load data held", rdata_o, 32'hCAFEF00D);
    run_txn(VECS[7], 1'b0);
    chk("R8 load data held over store", rdata_o, 32'hCAFEF00D);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule